// File: doc/BRIEF.md
# Two-Stage Clock Division Front End

This block sits at the head of one clock distribution channel. It contains a first-stage prescaler that divides the fast input clock by an integer from 1 to 6. The prescaler can also be routed around entirely, or parked so that it never fires. Next to the prescaler sits a route decoder. From the prescaler controls, the direct-to-output enable and the bypass status of the downstream channel divider, it decides where the channel output takes its clock from. It also flags configurations that cannot produce a clock.

The prescaler output is a single-cycle clock-enable pulse, `pre_tick_o`, synchronous to the input clock. The downstream channel divider counts these pulses. Prescaler bypass makes the pulse fire every cycle, just as divide-by-1 does. The two settings are still kept apart in the route decision. Divide-by-1 combined with a bypassed channel divider is illegal, and the output is forced static. Bypass combined with a bypassed channel divider is a legal divide-by-1 path. A new ratio code is adopted only when the running period ends, so no shortened period is ever emitted.

Top module: `twostage_div_front`

## Requirements
- R1: With the prescaler running (bypass 0, static 0) and a ratio code R in 1..6, `pre_tick_o` is high for exactly one cycle in every R cycles, and the counter stays below R.
- R2: Ratio codes 0 and 7 are reserved. They act as divide-by-1 (a pulse every cycle). While the prescaler is running and direct-to-output is off, they raise `cfg_illegal_o`.
- R3: A ratio code change made mid-period does not alter the period in progress. The new ratio applies from the pulse that ends the current period.
- R4: With prescaler bypass set, `pre_tick_o` is high on every cycle whatever the ratio code and static bit (bypass wins over static). With the direct path off, `src_sel_o` is 2 (prescaler straight out) when the channel divider is bypassed and 1 (channel divider) otherwise. `cfg_illegal_o` stays 0.
- R5: With static set and bypass clear, `pre_tick_o` stays low. With the direct path off, `src_sel_o` is 3 (static) and `cfg_illegal_o` is 0.
- R6: With direct-to-output enabled, `src_sel_o` is 0 (raw input clock) and `cfg_illegal_o` is 0, whatever the other controls are.
- R7: With the prescaler running at an effective ratio of 2 or more and the direct path off, `src_sel_o` is 1 when the channel divider is active and 2 when it is bypassed.
- R8: With the prescaler running at an effective ratio of 1, the channel divider bypassed and the direct path off, `src_sel_o` is 3 (static) and `cfg_illegal_o` is 1.
- R9: While reset is low, `pre_tick_o` is 0 and the counter is cleared. On the first clock edge after release the running prescaler pulses once, and after that it pulses every R cycles. Leaving static or bypass mode also restarts the count: the first pulse comes R cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 3 | Prescaler ratio code, 1..6 valid |
| pre_bypass | input | 1 | Route around the prescaler (not the same as divide-by-1) |
| pre_static | input | 1 | Park the prescaler with no pulses |
| direct_en | input | 1 | Send the raw input clock to the output |
| chan_bypass | input | 1 | Downstream channel divider is bypassed |
| pre_tick_o | output | 1 | Prescaler output pulse (clock enable for the channel divider) |
| src_sel_o | output | 2 | Output source: 0 raw, 1 channel divider, 2 prescaler, 3 static |
| cfg_illegal_o | output | 1 | Configuration cannot produce a clock or uses a reserved code |

## Verification
The pulse train is tested at every legal ratio, with ratios switched in the middle of a period, and after returning from bypass, static and reset. These runs separate a counter that reloads at the terminal count from one that reloads at once. The route decoder is driven through all the combinations that differ only in divide-by-1 versus bypass, and in channel bypass versus active. Those pairs are the only thing that separates the illegal static case from the legal divide-by-1 path. The reserved codes are tried with the channel divider both active and bypassed. This shows they divide like ratio 1 and still raise the flag.

// File: rtl/twostage_div_pkg.sv
`timescale 1ns/1ps
package twostage_div_pkg;
  localparam int CODE_W = 3;
  localparam int MAX_RATIO = 6;

  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_CHAN   = 2'd1,
    SRC_PRE    = 2'd2,
    SRC_STATIC = 2'd3
  } src_sel_e;

  // A code outside 1..max_ratio is reserved
  function automatic logic code_reserved(input logic [CODE_W-1:0] code,
                                         input int max_ratio);
    return (code == '0) || (int'(code) > max_ratio);
  endfunction

  // Effective ratio: reserved codes fall back to divide-by-1
  function automatic logic [CODE_W-1:0] eff_ratio(input logic [CODE_W-1:0] code,
                                                  input int max_ratio);
    return code_reserved(code, max_ratio) ? CODE_W'(1) : code;
  endfunction
endpackage

// File: rtl/twostage_mode_decode.sv
`timescale 1ns/1ps
module twostage_mode_decode (
  input  logic clk_in,
  input  logic rst_n,
  input  logic pre_bypass,
  input  logic pre_static,
  output logic mode_bypass,
  output logic mode_static,
  output logic mode_run
);
  // bypass dominates static
  assign mode_bypass = pre_bypass;
  assign mode_static = !pre_bypass && pre_static;
  assign mode_run    = !pre_bypass && !pre_static;

  // R4
  mode_onehot_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $countones({mode_bypass, mode_static, mode_run}) == 1);
endmodule

// File: rtl/twostage_prescaler.sv
`timescale 1ns/1ps
module twostage_prescaler #(
  parameter int CODE_W = 3,
  parameter int MAX_RATIO = 6
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              mode_bypass,
  input  logic              mode_static,
  input  logic              mode_run,
  input  logic [CODE_W-1:0] ratio_eff,
  output logic              tick_o,
  output logic              term_evt_o
);
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] cur_ratio_q;
  logic              tick_q;

  // terminal count of the period in progress
  assign term_evt_o = (cnt_q == cur_ratio_q - CODE_W'(1));
  assign tick_o     = tick_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      cur_ratio_q <= CODE_W'(1);
      tick_q      <= 1'b0;
    end else if (mode_bypass) begin
      cnt_q       <= '0;
      cur_ratio_q <= ratio_eff;
      tick_q      <= 1'b1;
    end else if (mode_static) begin
      cnt_q       <= '0;
      cur_ratio_q <= ratio_eff;
      tick_q      <= 1'b0;
    end else if (term_evt_o) begin
      cnt_q       <= '0;
      cur_ratio_q <= ratio_eff;
      tick_q      <= 1'b1;
    end else begin
      cnt_q       <= cnt_q + CODE_W'(1);
      tick_q      <= 1'b0;
    end
  end

  // R4
  bypass_tick_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    mode_bypass |=> tick_q);
  // R5
  static_quiet_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    mode_static |=> !tick_q);
  // R3
  ratio_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode_run && !term_evt_o) |=> $stable(cur_ratio_q));
  // R1
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt_q < cur_ratio_q);
  // R1
  run_tick_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    mode_run |=> (tick_q == $past(term_evt_o)));
  // R1
  ratio_legal_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cur_ratio_q != '0) && (int'(cur_ratio_q) <= MAX_RATIO));
endmodule

// File: rtl/twostage_route.sv
`timescale 1ns/1ps
module twostage_route
  import twostage_div_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              direct_en,
  input  logic              chan_bypass,
  input  logic              mode_bypass,
  input  logic              mode_static,
  input  logic              reserved,
  input  logic [CODE_W-1:0] ratio_eff,
  output src_sel_e          src_sel,
  output logic              illegal
);
  logic unity_ratio;
  assign unity_ratio = (ratio_eff == CODE_W'(1));

  always_comb begin
    illegal = 1'b0;
    src_sel = SRC_CHAN;
    if (direct_en) begin
      src_sel = SRC_DIRECT;
    end else if (mode_bypass) begin
      src_sel = chan_bypass ? SRC_PRE : SRC_CHAN;
    end else if (mode_static) begin
      src_sel = SRC_STATIC;
    end else begin
      illegal = reserved;
      if (chan_bypass && unity_ratio) begin
        src_sel = SRC_STATIC;
        illegal = 1'b1;
      end else if (chan_bypass) begin
        src_sel = SRC_PRE;
      end
    end
  end

  // R6
  direct_src_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    direct_en |-> (src_sel == SRC_DIRECT) && !illegal);
  // R8
  illegal_static_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (illegal && chan_bypass && !direct_en) |-> (src_sel == SRC_STATIC));
  // R2
  reserved_flag_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (reserved && !direct_en && !mode_bypass && !mode_static) |-> illegal);
  // R4
  bypass_legal_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    mode_bypass |-> !illegal);
endmodule

// File: rtl/twostage_div_front.sv
`timescale 1ns/1ps
module twostage_div_front
  import twostage_div_pkg::*;
#(
  parameter int CODE_W = twostage_div_pkg::CODE_W,
  parameter int MAX_RATIO = twostage_div_pkg::MAX_RATIO
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              pre_bypass,
  input  logic              pre_static,
  input  logic              direct_en,
  input  logic              chan_bypass,
  output logic              pre_tick_o,
  output logic [1:0]        src_sel_o,
  output logic              cfg_illegal_o
);
  logic              mode_bypass, mode_static, mode_run;
  logic              term_evt;
  logic              code_rsv;
  logic [CODE_W-1:0] ratio_eff;
  src_sel_e          src_sel;

  assign code_rsv  = code_reserved(ratio_code, MAX_RATIO);
  assign ratio_eff = eff_ratio(ratio_code, MAX_RATIO);

  twostage_mode_decode u_mode (
    .clk_in(clk_in), .rst_n(rst_n),
    .pre_bypass(pre_bypass), .pre_static(pre_static),
    .mode_bypass(mode_bypass), .mode_static(mode_static), .mode_run(mode_run)
  );

  twostage_prescaler #(.CODE_W(CODE_W), .MAX_RATIO(MAX_RATIO)) u_pre (
    .clk_in(clk_in), .rst_n(rst_n),
    .mode_bypass(mode_bypass), .mode_static(mode_static), .mode_run(mode_run),
    .ratio_eff(ratio_eff), .tick_o(pre_tick_o), .term_evt_o(term_evt)
  );

  twostage_route #(.CODE_W(CODE_W)) u_route (
    .clk_in(clk_in), .rst_n(rst_n),
    .direct_en(direct_en), .chan_bypass(chan_bypass),
    .mode_bypass(mode_bypass), .mode_static(mode_static),
    .reserved(code_rsv), .ratio_eff(ratio_eff),
    .src_sel(src_sel), .illegal(cfg_illegal_o)
  );

  assign src_sel_o = src_sel;

  // R9
  reset_quiet_chk: assert property (@(posedge clk_in)
    !rst_n |-> !pre_tick_o);
  // R1
  single_term_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode_run && term_evt && (ratio_eff != CODE_W'(1))) |=> !term_evt);
endmodule

// File: tb/tb_twostage_div_front.sv
`timescale 1ns/1ps
module tb_twostage_div_front;
  logic       clk_in = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_code = 3'd3;
  logic       pre_bypass = 1'b0;
  logic       pre_static = 1'b0;
  logic       direct_en = 1'b0;
  logic       chan_bypass = 1'b0;
  logic       pre_tick_o;
  logic [1:0] src_sel_o;
  logic       cfg_illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];
  int    m_left = 1;

  always #5 clk_in = ~clk_in;

  twostage_div_front dut (
    .clk_in(clk_in), .rst_n(rst_n), .ratio_code(ratio_code),
    .pre_bypass(pre_bypass), .pre_static(pre_static),
    .direct_en(direct_en), .chan_bypass(chan_bypass),
    .pre_tick_o(pre_tick_o), .src_sel_o(src_sel_o),
    .cfg_illegal_o(cfg_illegal_o)
  );

  function automatic int ratio_of(input logic [2:0] c);
    return (c >= 3'd1 && c <= 3'd6) ? int'(c) : 1;
  endfunction

  // monitor: compares each pulse slot after the edge
  initial begin
    forever begin
      @(posedge clk_in);
      #2;
      if (exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (pre_tick_o !== e) begin
          errors++;
          $display("FAIL %s tick actual=%0b expected=%0b", t, pre_tick_o, e);
        end
      end
    end
  end

  // driver: predicts the pulse for each coming edge, then lets it pass
  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic e;
      if (pre_bypass) begin
        e = 1'b1;
        m_left = ratio_of(ratio_code);
      end else if (pre_static) begin
        e = 1'b0;
        m_left = ratio_of(ratio_code);
      end else begin
        m_left--;
        if (m_left == 0) begin
          e = 1'b1;
          m_left = ratio_of(ratio_code);
        end else begin
          e = 1'b0;
        end
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk_in);
    end
  endtask

  task automatic chk_route(input logic [1:0] es, input logic ei, input string tag);
    #1;
    checks++;
    if (src_sel_o !== es || cfg_illegal_o !== ei) begin
      errors++;
      $display("FAIL %s route actual=%0d/%0b expected=%0d/%0b",
               tag, src_sel_o, cfg_illegal_o, es, ei);
    end
  endtask

  task automatic set_cfg(input logic [2:0] c, input logic byp, input logic st,
                         input logic dir, input logic cb);
    ratio_code = c; pre_bypass = byp; pre_static = st;
    direct_en = dir; chan_bypass = cb;
  endtask

  task automatic chk_low(input string tag);
    checks++;
    if (pre_tick_o !== 1'b0) begin
      errors++;
      $display("FAIL %s tick in reset actual=%0b expected=0", tag, pre_tick_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_in);
    chk_low("R9");
    rst_n = 1'b1;
    m_left = 1;
    run(1, "R9");
    run(9, "R1");
    set_cfg(3'd3, 0, 0, 0, 0); chk_route(2'd1, 0, "R7");
    set_cfg(3'd3, 0, 0, 0, 1); chk_route(2'd2, 0, "R7");
    run(4, "R1");
    // mid-period change
    set_cfg(3'd6, 0, 0, 0, 0);
    run(1, "R3");
    set_cfg(3'd2, 0, 0, 0, 0);
    run(14, "R3");
    set_cfg(3'd5, 0, 0, 0, 0); run(12, "R1");
    set_cfg(3'd4, 0, 0, 0, 0); run(11, "R1");
    set_cfg(3'd6, 0, 0, 0, 0); run(15, "R1");
    set_cfg(3'd2, 0, 0, 0, 1); chk_route(2'd2, 0, "R7"); run(6, "R1");
    set_cfg(3'd1, 0, 0, 0, 0); chk_route(2'd1, 0, "R7"); run(6, "R1");
    set_cfg(3'd1, 0, 0, 0, 1); chk_route(2'd3, 1, "R8"); run(3, "R8");
    set_cfg(3'd0, 0, 0, 0, 0); chk_route(2'd1, 1, "R2"); run(5, "R2");
    set_cfg(3'd7, 0, 0, 0, 1); chk_route(2'd3, 1, "R2"); run(4, "R2");
    // bypass differs from divide-by-1
    set_cfg(3'd1, 1, 0, 0, 1); chk_route(2'd2, 0, "R4"); run(4, "R4");
    set_cfg(3'd5, 1, 0, 0, 0); chk_route(2'd1, 0, "R4"); run(4, "R4");
    set_cfg(3'd5, 1, 1, 0, 1); chk_route(2'd2, 0, "R4"); run(4, "R4");
    set_cfg(3'd0, 1, 0, 0, 1); chk_route(2'd2, 0, "R4");
    set_cfg(3'd4, 0, 0, 0, 0); run(10, "R9");
    // static
    set_cfg(3'd3, 0, 1, 0, 0); chk_route(2'd3, 0, "R5"); run(8, "R5");
    set_cfg(3'd1, 0, 1, 0, 1); chk_route(2'd3, 0, "R5"); run(3, "R5");
    set_cfg(3'd1, 0, 1, 1, 1); chk_route(2'd0, 0, "R6");
    set_cfg(3'd3, 0, 0, 0, 0); run(8, "R9");
    // direct path
    set_cfg(3'd1, 0, 0, 1, 1); chk_route(2'd0, 0, "R6"); run(3, "R6");
    set_cfg(3'd0, 0, 0, 1, 0); chk_route(2'd0, 0, "R6");
    set_cfg(3'd4, 1, 0, 1, 1); chk_route(2'd0, 0, "R6"); run(2, "R6");
    // reset in mid-run
    set_cfg(3'd5, 0, 0, 0, 0); run(3, "R1");
    rst_n = 1'b0;
    #1 chk_low("R9");
    @(negedge clk_in);
    chk_low("R9");
    rst_n = 1'b1;
    m_left = 1;
    run(12, "R9");
    @(negedge clk_in);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule